// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital core of a three-phase integrating converter. It runs on the oscillator clock and derives a count clock from it. It steps the analog switch network through three phases: zeroing, signal integration and reference de-integration. It counts the de-integration time directly in BCD. At the end of every measurement it stores a signed reading with a half-digit and an overrange flag. The integrator, the comparator and the analog switches sit outside the block. The only analog feedback the block sees is the comparator level.

The measurement frame has a fixed length of four decades of counts. Signal integration is fixed at one decade. De-integration takes whatever time the integrator needs to return to zero, up to two decades. The zeroing phase absorbs the remainder, so readings come out at a constant rate whatever the input. The comparator level at the moment signal integration ends sets the polarity. That polarity selects which reference switch drives de-integration, and the end of de-integration is the first count at which the comparator leaves that level.

Top module: `dsadc_seq`

## Requirements
- R1: One count lasts exactly PRESCALE oscillator clocks, and every phase change happens on a count boundary, so every phase length is a whole multiple of PRESCALE clocks.
- R2: Signal integration (`ph_int_o`) lasts exactly 10^DIGITS counts.
- R3: A measurement frame, from one rise of `ph_int_o` to the next, lasts exactly 4·10^DIGITS counts whatever the reading.
- R4: If the comparator first differs from the captured polarity at count boundary k+1 of de-integration (k < 2·10^DIGITS), de-integration lasts k+1 counts. The reading is k, with units in bits [3:0] of `rd_digits_o`, each higher decade in the next four bits, and `rd_half_o` set when k ≥ 10^DIGITS.
- R5: If 2·10^DIGITS counts of de-integration pass without a crossing, de-integration ends after exactly that many counts and the result is `rd_ovr_o`=1, `rd_half_o`=1 and `rd_digits_o`=0.
- R6: The zeroing phase lasts 4·10^DIGITS − 10^DIGITS − d counts, where d is the length of the preceding de-integration, so it is never shorter than 10^DIGITS counts.
- R7: The comparator level at the end of signal integration is the polarity. Level 1 selects `ph_ref_neg_o` and gives `rd_neg_o`=0. Level 0 selects `ph_ref_pos_o` and gives `rd_neg_o`=1. This holds even when the crossing follows at once (reading 0).
- R8: The result outputs change only on the clock edge that ends de-integration. Comparator activity during zeroing or integration leaves them unchanged.
- R9: Exactly one of the four phase outputs is high in every cycle. The phases follow the order zeroing, integration, de-integration, zeroing.
- R10: A synchronous reset selects the zeroing phase and clears the result. The first signal integration begins 10^DIGITS counts after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator level: 1 when the integrator sits on the positive side |
| ph_az_o | output | 1 | Zeroing phase switch drive |
| ph_int_o | output | 1 | Signal integration switch drive |
| ph_ref_pos_o | output | 1 | De-integrate with positive reference (negative input) |
| ph_ref_neg_o | output | 1 | De-integrate with negative reference (positive input) |
| rd_digits_o | output | 4·DIGITS | Reading magnitude, BCD, units in the low nibble |
| rd_half_o | output | 1 | Leading half-digit (one) |
| rd_neg_o | output | 1 | Reading is negative |
| rd_ovr_o | output | 1 | Reading overranged |

## Verification
The assertions assume that the comparator input changes only between clock edges, because the polarity checks compare each selected reference switch with the comparator value one edge earlier. They do not assume that the comparator ever crosses. The de-integration bound and the overrange shape are meant to hold even for a comparator that never moves. The bench drives the comparator only on falling clock edges. It holds the level steady through the end of integration and flips it a programmed number of counts into de-integration, or never for overrange cases. During zeroing it toggles the comparator freely to show that the result ignores it.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    // Switch phase of the measurement frame; the two reference phases
    // carry the polarity chosen at the end of signal integration.
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DEP = 2'd2,
        PH_DEN = 2'd3
    } phase_e;

endpackage

// File: rtl/dsadc_tick.sv
// Count-clock enable: one cycle high out of every PRESCALE oscillator clocks.
module dsadc_tick #(
    parameter int PRESCALE = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dsadc_bcd.sv
// Decade counter chain with a leading half-digit, cleared and advanced
// by the sequencer; full_o flags the largest representable value.
module dsadc_bcd #(
    parameter int DIGITS = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                clr_i,
    input  logic                inc_i,
    output logic [4*DIGITS-1:0] digits_o,
    output logic                half_o,
    output logic                full_o
);
    logic [DIGITS:0]   carry;
    logic [DIGITS-1:0] nine;
    logic              half_d, half_q;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        logic [3:0] dig_d, dig_q;

        assign nine[g]           = (dig_q == 4'd9);
        assign carry[g+1]        = carry[g] & nine[g];
        assign digits_o[4*g +: 4] = dig_q;

        always_comb begin
            dig_d = dig_q;
            if (clr_i)         dig_d = 4'd0;
            else if (carry[g]) dig_d = nine[g] ? 4'd0 : dig_q + 4'd1;
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) dig_q <= 4'd0;
            else       dig_q <= dig_d;
        end
    end

    always_comb begin
        half_d = half_q;
        if (clr_i)              half_d = 1'b0;
        else if (carry[DIGITS]) half_d = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) half_q <= 1'b0;
        else       half_q <= half_d;
    end

    assign half_o = half_q;
    assign full_o = half_q & (&nine);
endmodule

// File: rtl/dsadc_seq.sv
// Three-phase integrating converter sequencer with BCD result latch.
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int DIGITS   = 3,
    parameter int PRESCALE = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                cmp_i,
    output logic                ph_az_o,
    output logic                ph_int_o,
    output logic                ph_ref_pos_o,
    output logic                ph_ref_neg_o,
    output logic [4*DIGITS-1:0] rd_digits_o,
    output logic                rd_half_o,
    output logic                rd_neg_o,
    output logic                rd_ovr_o
);
    localparam int SIG_CNT = 10 ** DIGITS;
    localparam int DE_MAX  = 2 * SIG_CNT;
    localparam int FRAME   = 4 * SIG_CNT;
    localparam int FW      = $clog2(FRAME);
    localparam int BW      = 4 * DIGITS;
    localparam logic [FW-1:0] F_LAST  = FW'(FRAME - 1);
    localparam logic [FW-1:0] I_LAST  = FW'(SIG_CNT - 1);
    localparam logic [FW-1:0] F_RESET = FW'(SIG_CNT + DE_MAX);

    typedef struct packed {
        phase_e          ph;
        logic [FW-1:0]   fpos;
        logic            sign;
        logic [BW-1:0]   digits;
        logic            half;
        logic            neg;
        logic            ovr;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic          tick;
    logic          bcd_clr, bcd_inc;
    logic [BW-1:0] bcd_digits;
    logic          bcd_half, bcd_full;
    logic          crossed;

    dsadc_tick #(.PRESCALE(PRESCALE)) tick_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    dsadc_bcd #(.DIGITS(DIGITS)) bcd_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clr_i    (bcd_clr),
        .inc_i    (bcd_inc),
        .digits_o (bcd_digits),
        .half_o   (bcd_half),
        .full_o   (bcd_full)
    );

    always_comb begin
        st_d    = st_q;
        bcd_clr = 1'b0;
        bcd_inc = 1'b0;
        crossed = (cmp_i != st_q.sign);
        if (tick) begin
            st_d.fpos = (st_q.fpos == F_LAST) ? '0 : st_q.fpos + 1'b1;
            unique case (st_q.ph)
                PH_AZ: begin
                    if (st_q.fpos == F_LAST) st_d.ph = PH_INT;
                end
                PH_INT: begin
                    if (st_q.fpos == I_LAST) begin
                        st_d.sign = cmp_i;
                        st_d.ph   = cmp_i ? PH_DEN : PH_DEP;
                        bcd_clr   = 1'b1;
                    end
                end
                default: begin
                    if (crossed) begin
                        st_d.ph     = PH_AZ;
                        st_d.digits = bcd_digits;
                        st_d.half   = bcd_half;
                        st_d.neg    = ~st_q.sign;
                        st_d.ovr    = 1'b0;
                    end else if (bcd_full) begin
                        st_d.ph     = PH_AZ;
                        st_d.digits = '0;
                        st_d.half   = 1'b1;
                        st_d.neg    = ~st_q.sign;
                        st_d.ovr    = 1'b1;
                    end else begin
                        bcd_inc = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.ph     <= PH_AZ;
            st_q.fpos   <= F_RESET;
            st_q.sign   <= 1'b0;
            st_q.digits <= '0;
            st_q.half   <= 1'b0;
            st_q.neg    <= 1'b0;
            st_q.ovr    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_az_o      = (st_q.ph == PH_AZ);
    assign ph_int_o     = (st_q.ph == PH_INT);
    assign ph_ref_pos_o = (st_q.ph == PH_DEP);
    assign ph_ref_neg_o = (st_q.ph == PH_DEN);
    assign rd_digits_o  = st_q.digits;
    assign rd_half_o    = st_q.half;
    assign rd_neg_o     = st_q.neg;
    assign rd_ovr_o     = st_q.ovr;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int DIGITS   = 3,
    parameter int PRESCALE = 4
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                cmp_i,
    input logic                ph_az_o,
    input logic                ph_int_o,
    input logic                ph_ref_pos_o,
    input logic                ph_ref_neg_o,
    input logic [4*DIGITS-1:0] rd_digits_o,
    input logic                rd_half_o,
    input logic                rd_neg_o,
    input logic                rd_ovr_o
);
    localparam int SIG_CNT = 10 ** DIGITS;
    localparam int INT_CLK = SIG_CNT * PRESCALE;
    localparam int DE_CLK  = 2 * SIG_CNT * PRESCALE;
    localparam int FR_CLK  = 4 * SIG_CNT * PRESCALE;

    logic de;
    assign de = ph_ref_pos_o | ph_ref_neg_o;

    int unsigned int_cnt_q, de_cnt_q, fr_cnt_q;
    logic        int_prev_q, seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            int_cnt_q  <= 0;
            de_cnt_q   <= 0;
            fr_cnt_q   <= 0;
            int_prev_q <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            int_cnt_q  <= ph_int_o ? int_cnt_q + 1 : 0;
            de_cnt_q   <= de ? de_cnt_q + 1 : 0;
            int_prev_q <= ph_int_o;
            if (ph_int_o && !int_prev_q) begin
                fr_cnt_q <= 1;
                seen_q   <= 1'b1;
            end else begin
                fr_cnt_q <= fr_cnt_q + 1;
            end
        end
    end

    a_r9_one_phase: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({ph_az_o, ph_int_o, ph_ref_pos_o, ph_ref_neg_o}) == 1);

    a_r9_int_after_az: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ph_int_o) |-> $past(ph_az_o));

    a_r9_de_after_int: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(de) |-> $past(ph_int_o));

    a_r2_int_length: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ph_int_o) |-> (int_cnt_q == INT_CLK));

    a_r5_de_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        de |-> (de_cnt_q < DE_CLK));

    a_r3_frame_length: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_int_o && !int_prev_q && seen_q) |-> (fr_cnt_q == FR_CLK));

    a_r8_result_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !de |=> $stable({rd_digits_o, rd_half_o, rd_neg_o, rd_ovr_o}));

    a_r5_ovr_shape: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_ovr_o |-> (rd_half_o && rd_digits_o == '0));

    a_r7_ref_neg_sel: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ph_ref_neg_o) |-> $past(cmp_i));

    a_r7_ref_pos_sel: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ph_ref_pos_o) |-> !$past(cmp_i));
endmodule

bind dsadc_seq dsadc_seq_chk #(.DIGITS(DIGITS), .PRESCALE(PRESCALE)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .cmp_i        (cmp_i),
    .ph_az_o      (ph_az_o),
    .ph_int_o     (ph_int_o),
    .ph_ref_pos_o (ph_ref_pos_o),
    .ph_ref_neg_o (ph_ref_neg_o),
    .rd_digits_o  (rd_digits_o),
    .rd_half_o    (rd_half_o),
    .rd_neg_o     (rd_neg_o),
    .rd_ovr_o     (rd_ovr_o)
);

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D     = 2;
    localparam int P     = 2;
    localparam int SIG   = 10 ** D;
    localparam int DEM   = 2 * SIG;
    localparam int FRAME = 4 * SIG;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmp = 1'b0;
    logic         ph_az, ph_int, ph_rp, ph_rn;
    logic [4*D-1:0] rd_digits;
    logic         rd_half, rd_neg, rd_ovr;

    int n_chk  = 0;
    int n_fail = 0;
    int prev_digits = 0;
    int prev_half   = 0;
    int prev_neg    = 0;
    int prev_ovr    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsadc_seq #(.DIGITS(D), .PRESCALE(P)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .cmp_i        (cmp),
        .ph_az_o      (ph_az),
        .ph_int_o     (ph_int),
        .ph_ref_pos_o (ph_rp),
        .ph_ref_neg_o (ph_rn),
        .rd_digits_o  (rd_digits),
        .rd_half_o    (rd_half),
        .rd_neg_o     (rd_neg),
        .rd_ovr_o     (rd_ovr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bcd_of(input int v);
        int r = 0;
        int x = v;
        for (int g = 0; g < D; g++) begin
            r = r | ((x % 10) << (4 * g));
            x = x / 10;
        end
        return r;
    endfunction

    // Entered at the first falling edge of signal integration.
    task automatic run_frame(input int n, input bit pos);
        int int_len, de_len, az_len, c, de_cnts;
        int e_digits, e_half, e_ovr;
        int h_digits, h_half, h_neg, h_ovr;
        bit flips;
        flips   = (n < DEM);
        cmp     = pos;
        int_len = 1;
        forever begin
            @(negedge clk);
            if (!ph_int) break;
            int_len++;
        end
        check(int_len == SIG * P, "R2 R1 integrate length", int_len, SIG * P);
        check(ph_rn == pos && ph_rp == !pos, "R7 reference select", {ph_rp, ph_rn}, {!pos, pos});
        check(rd_digits == prev_digits && rd_neg == prev_neg && rd_ovr == prev_ovr
              && rd_half == prev_half, "R8 result held through integrate",
              int'(rd_digits), prev_digits);
        de_len = 1;
        c      = 0;
        if (flips && c == n * P) cmp = !pos;
        forever begin
            @(negedge clk);
            c++;
            if (!(ph_rp || ph_rn)) break;
            de_len++;
            if (flips && c == n * P) cmp = !pos;
        end
        de_cnts  = flips ? n + 1 : DEM;
        e_digits = flips ? bcd_of(n) : 0;
        e_half   = flips ? int'(n >= SIG) : 1;
        e_ovr    = flips ? 0 : 1;
        check(de_len == de_cnts * P, flips ? "R4 deintegrate length" : "R5 deintegrate length",
              de_len, de_cnts * P);
        check(int'(rd_digits) == e_digits && int'(rd_half) == e_half,
              flips ? "R4 reading" : "R5 reading", int'({rd_half, rd_digits}), (e_half << (4*D)) | e_digits);
        check(int'(rd_ovr) == e_ovr, "R5 overrange flag", rd_ovr, e_ovr);
        check(rd_neg == !pos, "R7 polarity", rd_neg, !pos);
        check(ph_az && $countones({ph_az, ph_int, ph_rp, ph_rn}) == 1, "R9 back to zeroing",
              {ph_az, ph_int, ph_rp, ph_rn}, 8);
        h_digits = rd_digits; h_half = rd_half; h_neg = rd_neg; h_ovr = rd_ovr;
        az_len = 1;
        forever begin
            @(negedge clk);
            if (ph_int) break;
            az_len++;
            if (az_len % 7 == 0) cmp = !cmp;
        end
        check(az_len == (FRAME - SIG - de_cnts) * P, "R6 zeroing length", az_len,
              (FRAME - SIG - de_cnts) * P);
        check(int_len + de_len + az_len == FRAME * P, "R3 frame length",
              int_len + de_len + az_len, FRAME * P);
        check(int'(rd_digits) == h_digits && int'(rd_half) == h_half && int'(rd_neg) == h_neg
              && int'(rd_ovr) == h_ovr, "R8 result held through zeroing", int'(rd_digits), h_digits);
        prev_digits = h_digits; prev_half = h_half; prev_neg = h_neg; prev_ovr = h_ovr;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(ph_az && !ph_int && !ph_rp && !ph_rn, "R10 reset phase",
              {ph_az, ph_int, ph_rp, ph_rn}, 8);
        check(rd_digits == 0 && !rd_half && !rd_neg && !rd_ovr, "R10 reset result",
              int'({rd_ovr, rd_neg, rd_half, rd_digits}), 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ph_int);
        check(n == (FRAME - SIG - DEM) * P, "R10 first integrate start", n, (FRAME - SIG - DEM) * P);
        for (int k = 0; k <= 25; k++)   run_frame(k, (k % 2) == 0);
        for (int k = 89; k <= 111; k++) run_frame(k, (k % 2) == 1);
        for (int k = 190; k <= 201; k++) run_frame(k, (k % 3) != 0);
        run_frame(250, 1'b1);
        run_frame(250, 1'b0);
        run_frame(0, 1'b0);
        run_frame(199, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog: actual=hung expected=frames complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule